// File: doc/BRIEF.md
# Per-Thread Squash Request Controller

This block decides, for every hardware thread of an out-of-order core, when the in-flight instructions of that thread have to be discarded. It also tells the rest of the pipeline where the discard boundary lies. A squash can be requested in three ways: a trap that fires after a programmable delay, a request from the thread-context side, or a mispredict or replay reported by the execute stage. For each thread the block remembers the sequence number of the youngest instruction that is still valid. It uses that number to reject execute-stage squashes that are younger than an earlier one, so a younger squash cannot override an older one.

When a squash is accepted, the controller issues one registered broadcast. The broadcast gives the boundary sequence number, a squash pulse, a buffer-busy flag and the redirect information. The thread then stays in a recovering state, and the buffer-busy flag stays raised, until the reorder buffer reports that its walk-back is complete. Renamed instructions that arrive for a recovering thread are dropped. Instructions that arrive at any other time move the thread's youngest-valid number forward.

Top module: `squash_ctrl`

## Requirements
- R1: After reset, every thread has no squash pulse, a cleared buffer-busy flag, cause code 0 and a mispredict count of 0, and its youngest-valid number is 0.
- R2: A trap request on a running thread is sampled at a clock edge and puts the thread into trap-pending. With a latency setting of L, a full squash with cause code 1 is broadcast after the (L+2)-th following edge and at no earlier edge.
- R3: A thread-context request sampled at an edge produces a full squash with cause code 2 after the next edge.
- R4: If a fired trap and a pending thread-context request meet in the same cycle, the trap squash is broadcast first (cause 1). The context squash (cause 2) follows one cycle later.
- R5: A full squash uses as its boundary the buffer head sequence number minus one, or 0 when the buffer is empty. It redirects to the thread's restart PC, reports mispredict, taken and mispredicted PC as 0, and resets the youngest-valid number to 0.
- R6: An execute squash is accepted only when its sequence number is less than or equal to the thread's youngest-valid number and the thread is not in trap-pending. A rejected request produces no broadcast.
- R7: With the inclusive bit set, the boundary of an accepted execute squash is its sequence number minus one; otherwise it is the sequence number itself. The youngest-valid number becomes that boundary.
- R8: An accepted execute squash is broadcast one edge after it is presented. The broadcast carries cause code 3 and the request's mispredict flag, taken flag, redirect PC and mispredicted PC.
- R9: While a thread is recovering, the buffer-busy flag is re-raised each cycle until the buffer reports that it is done. The thread then returns to running and the flag drops.
- R10: A renamed instruction that arrives for a recovering thread is dropped and leaves the youngest-valid number unchanged.
- R11: An instruction inserted into a thread that is not recovering sets that thread's youngest-valid number to its sequence number.
- R12: Each thread's mispredict count increments on every accepted squash that carries the mispredict flag. It does not change otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_lat | input | LAT_W | Trap delay setting, in cycles |
| trap_req | input | NTHR | Per-thread trap request |
| ctx_req | input | NTHR | Per-thread thread-context squash request |
| ex_vld | input | NTHR | Execute-stage squash request valid |
| ex_seq | input | NTHR x SEQ_W | Sequence number of the squashing instruction |
| ex_incl | input | NTHR | Include the squashing instruction in the squash |
| ex_mis | input | NTHR | Request is a branch mispredict |
| ex_tkn | input | NTHR | Branch was taken |
| ex_npc | input | NTHR x PC_W | Redirect PC from execute |
| ex_mpc | input | NTHR x PC_W | PC of the mispredicted instruction |
| rob_empty | input | NTHR | Reorder buffer holds nothing for the thread |
| rob_head_seq | input | NTHR x SEQ_W | Sequence number at the buffer head |
| rob_done | input | NTHR | Buffer has finished its squash walk |
| restart_pc | input | NTHR x PC_W | Restart PC used by full squashes |
| ins_vld | input | 1 | A renamed instruction is offered for insertion |
| ins_tid | input | TID_W | Thread of the offered instruction |
| ins_seq | input | SEQ_W | Sequence number of the offered instruction |
| sq_valid | output | NTHR | Squash pulse (command to buffer and earlier stages) |
| sq_rob_busy | output | NTHR | Buffer is squashing for the thread |
| sq_bound | output | NTHR x SEQ_W | Squash boundary (done sequence number) |
| sq_cause | output | NTHR x 2 | 0 none, 1 trap, 2 context, 3 execute |
| sq_mis | output | NTHR | Broadcast mispredict flag |
| sq_tkn | output | NTHR | Broadcast taken flag |
| sq_npc | output | NTHR x PC_W | Broadcast redirect PC |
| sq_mpc | output | NTHR x PC_W | Broadcast mispredicted PC |
| mis_cnt | output | NTHR x CNT_W | Per-thread accepted-mispredict count |

## Verification
The hardest case to reach is a trap that fires in the very cycle in which a thread-context request is already pending. The trap must have been requested exactly one cycle before the context request, with the latency set to zero, so that the timer output and the pending flag meet. The bench therefore drives the trap request, then the context request one cycle later, and expects two full squashes in consecutive cycles in cause order 1 then 2. A second hard case is checking that instructions are dropped during recovery, because the youngest-valid number is not visible at the ports. That state is brought out through the age filter: after recovery ends, an execute squash at the dropped sequence number has to be refused.

// File: rtl/sqc_pkg.sv
package sqc_pkg;

    typedef enum logic [1:0] {
        TS_RUN  = 2'd0,
        TS_TRAP = 2'd1,
        TS_SQ   = 2'd2
    } tstate_e;

    typedef enum logic [1:0] {
        SC_NONE = 2'd0,
        SC_TRAP = 2'd1,
        SC_CTX  = 2'd2,
        SC_EXEC = 2'd3
    } cause_e;

endpackage

// File: rtl/sqc_trap_timer.sv
module sqc_trap_timer #(
    parameter int LAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LAT_W-1:0] lat,
    output logic             fire
);
    typedef struct packed {
        logic             busy;
        logic [LAT_W-1:0] cnt;
        logic             fire;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d      = q;
        d.fire = 1'b0;
        if (start) begin
            d.busy = 1'b1;
            d.cnt  = lat;
        end else if (q.busy) begin
            if (q.cnt == '0) begin
                d.busy = 1'b0;
                d.fire = 1'b1;
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign fire = q.fire;
endmodule

// File: rtl/sqc_thread.sv
module sqc_thread
    import sqc_pkg::*;
#(
    parameter int SEQ_W = 16,
    parameter int PC_W  = 32,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trap_req,
    input  logic             trap_fire,
    input  logic             ctx_req,
    input  logic             ex_vld,
    input  logic [SEQ_W-1:0] ex_seq,
    input  logic             ex_incl,
    input  logic             ex_mis,
    input  logic             ex_tkn,
    input  logic [PC_W-1:0]  ex_npc,
    input  logic [PC_W-1:0]  ex_mpc,
    input  logic             rob_empty,
    input  logic [SEQ_W-1:0] head_seq,
    input  logic             rob_done,
    input  logic [PC_W-1:0]  restart_pc,
    input  logic             ins_hit,
    input  logic [SEQ_W-1:0] ins_seq,
    output logic             trap_start,
    output logic             sq,
    output logic             robsq,
    output logic [SEQ_W-1:0] bound,
    output logic [1:0]       cause,
    output logic             mis,
    output logic             tkn,
    output logic [PC_W-1:0]  npc,
    output logic [PC_W-1:0]  mpc,
    output logic [CNT_W-1:0] mcnt
);
    typedef struct packed {
        tstate_e          st;
        logic [SEQ_W-1:0] yng;
        logic             ctx;
        logic             sq;
        logic             robsq;
        logic [SEQ_W-1:0] bound;
        cause_e           cause;
        logic             mis;
        logic             tkn;
        logic [PC_W-1:0]  npc;
        logic [PC_W-1:0]  mpc;
        logic [CNT_W-1:0] cnt;
    } thr_t;

    thr_t q, d;
    logic [SEQ_W-1:0] full_bnd;
    logic [SEQ_W-1:0] ex_bnd;

    always_comb begin
        full_bnd   = rob_empty ? '0 : head_seq - 1'b1;
        ex_bnd     = ex_incl ? ex_seq - 1'b1 : ex_seq;
        trap_start = 1'b0;

        d       = q;
        d.sq    = 1'b0;
        d.robsq = 1'b0;
        d.bound = '0;
        d.cause = SC_NONE;
        d.mis   = 1'b0;
        d.tkn   = 1'b0;
        d.npc   = '0;
        d.mpc   = '0;
        d.ctx   = q.ctx | ctx_req;

        // recovery in progress: finish or keep the buffer flag raised
        if (q.st == TS_SQ) begin
            if (rob_done) d.st    = TS_RUN;
            else          d.robsq = 1'b1;
        end

        // full-thread squash; a fired trap wins over a context request
        if (trap_fire || q.ctx) begin
            d.st    = TS_SQ;
            d.yng   = '0;
            d.sq    = 1'b1;
            d.robsq = 1'b1;
            d.bound = full_bnd;
            d.npc   = restart_pc;
            if (trap_fire) begin
                d.cause = SC_TRAP;
            end else begin
                d.cause = SC_CTX;
                d.ctx   = ctx_req;
            end
        end

        // execute-stage squash, filtered by age and trap state
        if (ex_vld && d.st != TS_TRAP && ex_seq <= d.yng) begin
            d.st    = TS_SQ;
            d.yng   = ex_bnd;
            d.sq    = 1'b1;
            d.robsq = 1'b1;
            d.bound = ex_bnd;
            d.cause = SC_EXEC;
            d.mis   = ex_mis;
            d.tkn   = ex_tkn;
            d.npc   = ex_npc;
            d.mpc   = ex_mpc;
            if (ex_mis) d.cnt = q.cnt + 1'b1;
        end

        // renamed instructions enter only when not recovering
        if (ins_hit && d.st != TS_SQ) d.yng = ins_seq;

        if (trap_req && d.st == TS_RUN) begin
            d.st       = TS_TRAP;
            trap_start = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= TS_RUN;
            q.cause <= SC_NONE;
        end else begin
            q <= d;
        end
    end

    assign sq    = q.sq;
    assign robsq = q.robsq;
    assign bound = q.bound;
    assign cause = q.cause;
    assign mis   = q.mis;
    assign tkn   = q.tkn;
    assign npc   = q.npc;
    assign mpc   = q.mpc;
    assign mcnt  = q.cnt;
endmodule

// File: rtl/squash_ctrl.sv
module squash_ctrl #(
    parameter int NTHR  = 2,
    parameter int SEQ_W = 16,
    parameter int PC_W  = 32,
    parameter int LAT_W = 8,
    parameter int CNT_W = 8,
    localparam int TID_W = (NTHR > 1) ? $clog2(NTHR) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [LAT_W-1:0]            trap_lat,
    input  logic [NTHR-1:0]             trap_req,
    input  logic [NTHR-1:0]             ctx_req,
    input  logic [NTHR-1:0]             ex_vld,
    input  logic [NTHR-1:0][SEQ_W-1:0]  ex_seq,
    input  logic [NTHR-1:0]             ex_incl,
    input  logic [NTHR-1:0]             ex_mis,
    input  logic [NTHR-1:0]             ex_tkn,
    input  logic [NTHR-1:0][PC_W-1:0]   ex_npc,
    input  logic [NTHR-1:0][PC_W-1:0]   ex_mpc,
    input  logic [NTHR-1:0]             rob_empty,
    input  logic [NTHR-1:0][SEQ_W-1:0]  rob_head_seq,
    input  logic [NTHR-1:0]             rob_done,
    input  logic [NTHR-1:0][PC_W-1:0]   restart_pc,
    input  logic                        ins_vld,
    input  logic [TID_W-1:0]            ins_tid,
    input  logic [SEQ_W-1:0]            ins_seq,
    output logic [NTHR-1:0]             sq_valid,
    output logic [NTHR-1:0]             sq_rob_busy,
    output logic [NTHR-1:0][SEQ_W-1:0]  sq_bound,
    output logic [NTHR-1:0][1:0]        sq_cause,
    output logic [NTHR-1:0]             sq_mis,
    output logic [NTHR-1:0]             sq_tkn,
    output logic [NTHR-1:0][PC_W-1:0]   sq_npc,
    output logic [NTHR-1:0][PC_W-1:0]   sq_mpc,
    output logic [NTHR-1:0][CNT_W-1:0]  mis_cnt
);
    logic [NTHR-1:0] trap_start;
    logic [NTHR-1:0] trap_fire;
    logic [NTHR-1:0] ins_hit;

    for (genvar t = 0; t < NTHR; t++) begin : g_thr
        assign ins_hit[t] = ins_vld && (ins_tid == TID_W'(t));

        sqc_trap_timer #(.LAT_W(LAT_W)) u_tmr (
            .clk   (clk),
            .rst_n (rst_n),
            .start (trap_start[t]),
            .lat   (trap_lat),
            .fire  (trap_fire[t])
        );

        sqc_thread #(.SEQ_W(SEQ_W), .PC_W(PC_W), .CNT_W(CNT_W)) u_thr (
            .clk        (clk),
            .rst_n      (rst_n),
            .trap_req   (trap_req[t]),
            .trap_fire  (trap_fire[t]),
            .ctx_req    (ctx_req[t]),
            .ex_vld     (ex_vld[t]),
            .ex_seq     (ex_seq[t]),
            .ex_incl    (ex_incl[t]),
            .ex_mis     (ex_mis[t]),
            .ex_tkn     (ex_tkn[t]),
            .ex_npc     (ex_npc[t]),
            .ex_mpc     (ex_mpc[t]),
            .rob_empty  (rob_empty[t]),
            .head_seq   (rob_head_seq[t]),
            .rob_done   (rob_done[t]),
            .restart_pc (restart_pc[t]),
            .ins_hit    (ins_hit[t]),
            .ins_seq    (ins_seq),
            .trap_start (trap_start[t]),
            .sq         (sq_valid[t]),
            .robsq      (sq_rob_busy[t]),
            .bound      (sq_bound[t]),
            .cause      (sq_cause[t]),
            .mis        (sq_mis[t]),
            .tkn        (sq_tkn[t]),
            .npc        (sq_npc[t]),
            .mpc        (sq_mpc[t]),
            .mcnt       (mis_cnt[t])
        );
    end
endmodule

// File: rtl/sqc_chk.sv
module sqc_chk #(
    parameter int NTHR  = 2,
    parameter int PC_W  = 32,
    parameter int CNT_W = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NTHR-1:0]            rob_done,
    input logic [NTHR-1:0]            sq_valid,
    input logic [NTHR-1:0]            sq_rob_busy,
    input logic [NTHR-1:0][1:0]       sq_cause,
    input logic [NTHR-1:0]            sq_mis,
    input logic [NTHR-1:0]            sq_tkn,
    input logic [NTHR-1:0][PC_W-1:0]  sq_mpc,
    input logic [NTHR-1:0][CNT_W-1:0] mis_cnt
);
    for (genvar t = 0; t < NTHR; t++) begin : g_chk
        // R1: no cause code without a squash pulse
        a_r1_idle_cause: assert property (@(posedge clk) disable iff (!rst_n)
            !sq_valid[t] |-> sq_cause[t] == 2'd0);

        // R5: full squashes carry no branch information
        a_r5_full_clean: assert property (@(posedge clk) disable iff (!rst_n)
            (sq_valid[t] && sq_cause[t] != 2'd3) |-> (!sq_mis[t] && !sq_tkn[t] && sq_mpc[t] == '0));

        // R8: every squash raises the buffer-busy flag
        a_r8_busy_with_squash: assert property (@(posedge clk) disable iff (!rst_n)
            sq_valid[t] |-> sq_rob_busy[t]);

        // R9: busy flag held until the buffer reports done
        a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (sq_rob_busy[t] && !rob_done[t]) |=> sq_rob_busy[t]);

        // R12: counter steps on a mispredict squash
        a_r12_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
            (sq_valid[t] && sq_mis[t]) |-> mis_cnt[t] == CNT_W'($past(mis_cnt[t]) + 1'b1));

        // R12: counter holds otherwise
        a_r12_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !(sq_valid[t] && sq_mis[t]) |-> $stable(mis_cnt[t]));
    end
endmodule

bind squash_ctrl sqc_chk #(.NTHR(NTHR), .PC_W(PC_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rob_done    (rob_done),
    .sq_valid    (sq_valid),
    .sq_rob_busy (sq_rob_busy),
    .sq_cause    (sq_cause),
    .sq_mis      (sq_mis),
    .sq_tkn      (sq_tkn),
    .sq_mpc      (sq_mpc),
    .mis_cnt     (mis_cnt)
);

// File: tb/tb_squash_ctrl.sv
`timescale 1ns/1ps
module tb_squash_ctrl;
    localparam int NTHR = 2, SEQ_W = 16, PC_W = 32, LAT_W = 8, CNT_W = 8;
    localparam int TID_W = 1;

    logic clk = 1'b0;
    logic rst_n;
    logic [LAT_W-1:0]           trap_lat;
    logic [NTHR-1:0]            trap_req, ctx_req, ex_vld, ex_incl, ex_mis, ex_tkn;
    logic [NTHR-1:0][SEQ_W-1:0] ex_seq, rob_head_seq;
    logic [NTHR-1:0][PC_W-1:0]  ex_npc, ex_mpc, restart_pc;
    logic [NTHR-1:0]            rob_empty, rob_done;
    logic                       ins_vld;
    logic [TID_W-1:0]           ins_tid;
    logic [SEQ_W-1:0]           ins_seq;
    logic [NTHR-1:0]            sq_valid, sq_rob_busy, sq_mis, sq_tkn;
    logic [NTHR-1:0][SEQ_W-1:0] sq_bound;
    logic [NTHR-1:0][1:0]       sq_cause;
    logic [NTHR-1:0][PC_W-1:0]  sq_npc, sq_mpc;
    logic [NTHR-1:0][CNT_W-1:0] mis_cnt;

    int total = 0;
    int fails = 0;

    always #5 clk = ~clk;

    squash_ctrl #(.NTHR(NTHR), .SEQ_W(SEQ_W), .PC_W(PC_W), .LAT_W(LAT_W), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .trap_lat(trap_lat), .trap_req(trap_req), .ctx_req(ctx_req),
        .ex_vld(ex_vld), .ex_seq(ex_seq), .ex_incl(ex_incl), .ex_mis(ex_mis), .ex_tkn(ex_tkn),
        .ex_npc(ex_npc), .ex_mpc(ex_mpc), .rob_empty(rob_empty), .rob_head_seq(rob_head_seq),
        .rob_done(rob_done), .restart_pc(restart_pc), .ins_vld(ins_vld), .ins_tid(ins_tid),
        .ins_seq(ins_seq), .sq_valid(sq_valid), .sq_rob_busy(sq_rob_busy), .sq_bound(sq_bound),
        .sq_cause(sq_cause), .sq_mis(sq_mis), .sq_tkn(sq_tkn), .sq_npc(sq_npc), .sq_mpc(sq_mpc),
        .mis_cnt(mis_cnt)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        trap_lat = '0; trap_req = '0; ctx_req = '0; ex_vld = '0; ex_incl = '0;
        ex_mis = '0; ex_tkn = '0; ex_seq = '0; ex_npc = '0; ex_mpc = '0;
        rob_empty = '0; rob_head_seq = '0; rob_done = '1; restart_pc = '0;
        ins_vld = 1'b0; ins_tid = '0; ins_seq = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic insert(input int t, input int seq);
        ins_vld = 1'b1; ins_tid = TID_W'(t); ins_seq = SEQ_W'(seq);
        @(negedge clk);
        ins_vld = 1'b0;
    endtask

    task automatic ex_pulse(input int t, input int seq, input bit incl, input bit mis,
                            input bit tkn, input int npc, input int mpc);
        ex_vld[t] = 1'b1; ex_seq[t] = SEQ_W'(seq); ex_incl[t] = incl;
        ex_mis[t] = mis; ex_tkn[t] = tkn; ex_npc[t] = PC_W'(npc); ex_mpc[t] = PC_W'(mpc);
        @(negedge clk);
        ex_vld[t] = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        for (int t = 0; t < NTHR; t++) begin
            chk("R1 squash idle", sq_valid[t], 0);
            chk("R1 busy idle", sq_rob_busy[t], 0);
            chk("R1 cause idle", sq_cause[t], 0);
            chk("R1 count zero", mis_cnt[t], 0);
        end
        // youngest-valid is 0 after reset: seq 0 accepted, seq 1 refused
        ex_pulse(1, 1, 0, 0, 0, 0, 0);
        chk("R1 youngest zero rejects 1", sq_valid[1], 0);
    endtask

    task automatic t_exec();
        do_reset();
        insert(0, 20);
        ex_pulse(0, 15, 0, 1, 1, 'h100, 'h200);
        chk("R8 squash", sq_valid[0], 1);
        chk("R8 cause", sq_cause[0], 3);
        chk("R7 bound exclusive", sq_bound[0], 15);
        chk("R8 mis", sq_mis[0], 1);
        chk("R8 taken", sq_tkn[0], 1);
        chk("R8 npc", sq_npc[0], 'h100);
        chk("R8 mpc", sq_mpc[0], 'h200);
        chk("R12 count", mis_cnt[0], 1);
        chk("R8 other thread quiet", sq_valid[1], 0);
        @(negedge clk);
        chk("R9 busy drops on done", sq_rob_busy[0], 0);
        ex_pulse(0, 16, 0, 1, 0, 0, 0);
        chk("R7 youngest set to boundary", sq_valid[0], 0);
        ex_pulse(0, 15, 1, 0, 0, 'h44, 0);
        chk("R7 accepted at boundary", sq_valid[0], 1);
        chk("R7 bound inclusive", sq_bound[0], 14);
        chk("R12 no count without mis", mis_cnt[0], 1);
    endtask

    task automatic t_age();
        do_reset();
        insert(1, 10);
        ex_pulse(1, 11, 0, 1, 0, 0, 0);
        chk("R6 younger rejected", sq_valid[1], 0);
        chk("R12 rejected not counted", mis_cnt[1], 0);
        ex_pulse(1, 10, 0, 0, 0, 0, 0);
        chk("R6 equal accepted", sq_valid[1], 1);
    endtask

    task automatic t_hold();
        do_reset();
        rob_done[0] = 1'b0;
        insert(0, 10);
        ex_pulse(0, 10, 0, 0, 0, 0, 0);
        chk("R9 squash", sq_valid[0], 1);
        insert(0, 50);
        chk("R9 busy held 1", sq_rob_busy[0], 1);
        @(negedge clk);
        chk("R9 busy held 2", sq_rob_busy[0], 1);
        @(negedge clk);
        chk("R9 busy held 3", sq_rob_busy[0], 1);
        rob_done[0] = 1'b1;
        @(negedge clk);
        chk("R9 busy released", sq_rob_busy[0], 0);
        ex_pulse(0, 50, 0, 0, 0, 0, 0);
        chk("R10 insert dropped while recovering", sq_valid[0], 0);
        insert(0, 50);
        ex_pulse(0, 50, 0, 0, 0, 0, 0);
        chk("R11 insert updates youngest", sq_valid[0], 1);
    endtask

    task automatic t_ctx();
        do_reset();
        insert(1, 30);
        rob_head_seq[1] = 7; restart_pc[1] = 'hABC;
        ctx_req[1] = 1'b1;
        @(negedge clk);
        ctx_req[1] = 1'b0;
        chk("R3 not yet", sq_valid[1], 0);
        @(negedge clk);
        chk("R3 squash", sq_valid[1], 1);
        chk("R3 cause", sq_cause[1], 2);
        chk("R5 bound head-1", sq_bound[1], 6);
        chk("R5 npc", sq_npc[1], 'hABC);
        chk("R5 mis clear", sq_mis[1], 0);
        ex_pulse(1, 5, 0, 0, 0, 0, 0);
        chk("R5 youngest reset", sq_valid[1], 0);
        rob_empty[1] = 1'b1;
        ctx_req[1] = 1'b1;
        @(negedge clk);
        ctx_req[1] = 1'b0;
        @(negedge clk);
        chk("R5 empty bound", sq_bound[1], 0);
    endtask

    task automatic t_trap();
        do_reset();
        insert(0, 40);
        trap_lat = 3;
        trap_req[0] = 1'b1;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            chk("R2 trap timing", sq_valid[0], (k == 6));
            if (k == 1) begin
                trap_req[0] = 1'b0;
                ex_vld[0] = 1'b1; ex_seq[0] = 5;
            end
            if (k == 2) ex_vld[0] = 1'b0; // R6: refused while trap pending
        end
        chk("R2 cause", sq_cause[0], 1);
    endtask

    task automatic t_prio();
        do_reset();
        trap_lat = 0;
        trap_req[1] = 1'b1;
        @(negedge clk);
        trap_req[1] = 1'b0;
        ctx_req[1] = 1'b1;
        chk("R4 quiet 0", sq_valid[1], 0);
        @(negedge clk);
        ctx_req[1] = 1'b0;
        chk("R4 quiet 1", sq_valid[1], 0);
        @(negedge clk);
        chk("R4 trap first", sq_cause[1], 1);
        @(negedge clk);
        chk("R4 context next", sq_cause[1], 2);
    endtask

    initial begin
        t_reset();
        t_exec();
        t_age();
        t_hold();
        t_ctx();
        t_trap();
        t_prio();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule